// File: doc/BRIEF.md
# Active Image Window and Sample Range Clipper

This block sits between a display timing generator and a 4:2:2 pixel source. Each cycle the timing side presents one interleaved sample position: an active-video flag plus the pixel index and line index within the active area. The block decides whether that position lies in a programmable image rectangle. The rectangle is set by a horizontal offset, a width, a vertical offset and a height, all counted inside the active area. Inside the rectangle it raises a data request, and the source answers with one sample on the following cycle. Everywhere else it substitutes black and takes nothing from the source.

Every sample leaving the block, whether it came from the source or is substituted black, is limited to a legal range. The floor is shared by all samples. The ceiling depends on whether the sample is luma or chroma. The three limits sit in registers that a load strobe updates and that reset to broadcast-legal defaults. The output sample and a delayed copy of the active flag leave through registers. Both appear two cycles after the position was presented, so they stay aligned with each other.

Top module: `active_window_clip`

## Requirements
- R1: `reqOut` is high in the same cycle exactly when `actIn` is high, `hOffIn <= xIn < hOffIn + hSizeIn` and `vOffIn <= yIn < vOffIn + vSizeIn`. The sums are evaluated without overflow.
- R2: For a position presented with `reqOut` high in cycle t, `srcData` is taken in cycle t+1 and the clipped value appears on `dataOut` in cycle t+2.
- R3: For a position with `reqOut` low, `srcData` is ignored. `dataOut` in cycle t+2 is clipped black: 16 for luma and 128 for chroma.
- R4: The sample kind is taken from `xIn[1:0]`: 0 is Cb, 1 is Y, 2 is Cr, 3 is Y. Odd positions are luma and even positions are chroma.
- R5: A value below the lower limit is output as the lower limit.
- R6: A luma value above the luma upper limit is output as that limit.
- R7: A chroma value above the chroma upper limit is output as that limit. The lower limit is applied first and the upper limit second, so the upper limit wins if they conflict.
- R8: After reset the limits are 16 (lower), 235 (luma upper) and 240 (chroma upper). A cycle with `cfgLoad` high loads `clipLoIn`, `clipHiLumaIn` and `clipHiChromaIn`, and the new limits take effect from the next cycle.
- R9: `actOut` equals `actIn` delayed by two cycles. During reset, `actOut` and `dataOut` are 0.
- R10: A width or height of zero produces no request anywhere in the frame, and the whole active area outputs clipped black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| actIn | input | 1 | Active-video flag from the timing generator |
| xIn | input | XW | Sample index within the active line |
| yIn | input | YW | Line index within the active area |
| hOffIn | input | XW | Horizontal offset of the image rectangle |
| hSizeIn | input | XW | Width of the image rectangle, in samples |
| vOffIn | input | YW | Vertical offset of the image rectangle |
| vSizeIn | input | YW | Height of the image rectangle, in lines |
| cfgLoad | input | 1 | Load strobe for the clip limits |
| clipLoIn | input | DW | New lower limit |
| clipHiLumaIn | input | DW | New luma upper limit |
| clipHiChromaIn | input | DW | New chroma upper limit |
| reqOut | output | 1 | Data request to the pixel source |
| srcData | input | DW | Source sample, valid one cycle after a request |
| dataOut | output | DW | Registered, clipped output sample |
| actOut | output | 1 | Active flag aligned with dataOut |

## Verification
The bench sweeps whole small frames with rectangles at several places. These include one flush with the left and right edges and one ending on the last line. Off-by-one errors in the bounds show up as requests one sample or one line too early or too late. A source pattern that spans the full 8-bit range drives values under the floor and over both ceilings, under the default limits and under loaded ones. A design that swapped the luma and chroma ceilings, or took the kind from the wrong index bit, would miscompare on alternating samples. Zero-sized rectangles and a garbage value driven on `srcData` whenever no request is pending catch a design that requests or consumes samples outside the window. A second reset checks that the limits return to their defaults.

// File: rtl/awc_pkg.sv
package awc_pkg;

  // Sample kind within the 4:2:2 interleave; bit 0 set means luma.
  typedef enum logic [1:0] {
    KIND_CB = 2'd0,
    KIND_Y0 = 2'd1,
    KIND_CR = 2'd2,
    KIND_Y1 = 2'd3
  } sampleKind_e;

  // Strobes passed from the window control to the sample datapath.
  typedef struct packed {
    logic        act;   // active-video flag, one stage delayed
    logic        take;  // source sample is to be used this cycle
    sampleKind_e kind;  // kind of the sample being produced
  } winStrobe_t;

endpackage

// File: rtl/awc_span_cmp.sv
module awc_span_cmp #(
  parameter int W = 11
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] len,
  output logic         hit
);

  localparam int EW = W + 1;

  logic [EW-1:0] posExt;
  logic [EW-1:0] startExt;
  logic [EW-1:0] stopExt;

  // One extra bit keeps start+len from wrapping.
  always_comb begin
    posExt   = {1'b0, pos};
    startExt = {1'b0, start};
    stopExt  = startExt + {1'b0, len};
    hit      = (posExt >= startExt) && (posExt < stopExt);
  end

endmodule

// File: rtl/awc_window_ctrl.sv
module awc_window_ctrl
  import awc_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          actIn,
  input  logic [XW-1:0] xIn,
  input  logic [YW-1:0] yIn,
  input  logic [XW-1:0] hOffIn,
  input  logic [XW-1:0] hSizeIn,
  input  logic [YW-1:0] vOffIn,
  input  logic [YW-1:0] vSizeIn,
  output logic          reqOut,
  output winStrobe_t    strobeOut
);

  localparam int AXES = 2;

  logic [AXES-1:0] axisHit;

  // The two axes share one comparator; each gets its own width.
  for (genvar a = 0; a < AXES; a++) begin : g_axis
    if (a == 0) begin : g_h
      awc_span_cmp #(.W(XW)) cmp_i (
        .pos  (xIn),
        .start(hOffIn),
        .len  (hSizeIn),
        .hit  (axisHit[a])
      );
    end else begin : g_v
      awc_span_cmp #(.W(YW)) cmp_i (
        .pos  (yIn),
        .start(vOffIn),
        .len  (vSizeIn),
        .hit  (axisHit[a])
      );
    end
  end

  always_comb begin
    reqOut = actIn && (&axisHit);
  end

  // The source answers a request one cycle later; the strobes move with it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeOut <= '0;
    end else begin
      strobeOut.act  <= actIn;
      strobeOut.take <= reqOut;
      strobeOut.kind <= sampleKind_e'(xIn[1:0]);
    end
  end

endmodule

// File: rtl/awc_sample_path.sv
module awc_sample_path
  import awc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgLoad,
  input  logic [DW-1:0] clipLoIn,
  input  logic [DW-1:0] clipHiLumaIn,
  input  logic [DW-1:0] clipHiChromaIn,
  input  winStrobe_t    strobeIn,
  input  logic [DW-1:0] srcData,
  output logic [DW-1:0] dataOut,
  output logic          actOut
);

  // Nominal 8-bit levels scaled to the sample width.
  localparam int            SH       = DW - 8;
  localparam logic [DW-1:0] LO_DEF   = DW'(16)  << SH;
  localparam logic [DW-1:0] HIY_DEF  = DW'(235) << SH;
  localparam logic [DW-1:0] HIC_DEF  = DW'(240) << SH;
  localparam logic [DW-1:0] BLACK_Y  = DW'(16)  << SH;
  localparam logic [DW-1:0] BLACK_C  = DW'(1)   << (DW - 1);

  logic [DW-1:0] loQ;
  logic [DW-1:0] hiLumaQ;
  logic [DW-1:0] hiChromaQ;

  logic          isLuma;
  logic [DW-1:0] picked;
  logic [DW-1:0] ceiling;
  logic [DW-1:0] floored;
  logic [DW-1:0] clipped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ       <= LO_DEF;
      hiLumaQ   <= HIY_DEF;
      hiChromaQ <= HIC_DEF;
    end else if (cfgLoad) begin
      loQ       <= clipLoIn;
      hiLumaQ   <= clipHiLumaIn;
      hiChromaQ <= clipHiChromaIn;
    end
  end

  always_comb begin
    isLuma  = (strobeIn.kind == KIND_Y0) || (strobeIn.kind == KIND_Y1);
    if (strobeIn.take) begin
      picked = srcData;
    end else begin
      picked = isLuma ? BLACK_Y : BLACK_C;
    end
    ceiling = isLuma ? hiLumaQ : hiChromaQ;
    // Floor first, ceiling second: the ceiling wins on conflict.
    floored = (picked < loQ) ? loQ : picked;
    clipped = (floored > ceiling) ? ceiling : floored;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      actOut  <= 1'b0;
    end else begin
      dataOut <= clipped;
      actOut  <= strobeIn.act;
    end
  end

endmodule

// File: rtl/active_window_clip.sv
module active_window_clip
  import awc_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          actIn,
  input  logic [XW-1:0] xIn,
  input  logic [YW-1:0] yIn,
  input  logic [XW-1:0] hOffIn,
  input  logic [XW-1:0] hSizeIn,
  input  logic [YW-1:0] vOffIn,
  input  logic [YW-1:0] vSizeIn,
  input  logic          cfgLoad,
  input  logic [DW-1:0] clipLoIn,
  input  logic [DW-1:0] clipHiLumaIn,
  input  logic [DW-1:0] clipHiChromaIn,
  output logic          reqOut,
  input  logic [DW-1:0] srcData,
  output logic [DW-1:0] dataOut,
  output logic          actOut
);

  winStrobe_t ctlStrobe;

  awc_window_ctrl #(.XW(XW), .YW(YW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .actIn    (actIn),
    .xIn      (xIn),
    .yIn      (yIn),
    .hOffIn   (hOffIn),
    .hSizeIn  (hSizeIn),
    .vOffIn   (vOffIn),
    .vSizeIn  (vSizeIn),
    .reqOut   (reqOut),
    .strobeOut(ctlStrobe)
  );

  awc_sample_path #(.DW(DW)) path_i (
    .clk           (clk),
    .rstN          (rstN),
    .cfgLoad       (cfgLoad),
    .clipLoIn      (clipLoIn),
    .clipHiLumaIn  (clipHiLumaIn),
    .clipHiChromaIn(clipHiChromaIn),
    .strobeIn      (ctlStrobe),
    .srcData       (srcData),
    .dataOut       (dataOut),
    .actOut        (actOut)
  );

endmodule

// File: rtl/active_window_clip_chk.sv
module active_window_clip_chk #(
  parameter int XW = 11,
  parameter int YW = 10,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          actIn,
  input logic          xLsb,
  input logic [XW-1:0] hSizeIn,
  input logic [YW-1:0] vSizeIn,
  input logic          cfgLoad,
  input logic          reqOut,
  input logic [DW-1:0] dataOut,
  input logic          actOut
);

  localparam int            SH      = DW - 8;
  localparam logic [DW-1:0] LO_DEF  = DW'(16)  << SH;
  localparam logic [DW-1:0] HIY_DEF = DW'(235) << SH;
  localparam logic [DW-1:0] HIC_DEF = DW'(240) << SH;

  logic [1:0] sinceRst;
  logic       warm;
  logic       loadedSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst   <= '0;
      loadedSeen <= 1'b0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      if (cfgLoad) loadedSeen <= 1'b1;
    end
  end

  assign warm = (sinceRst >= 2'd2);

  // R1: a request only occurs inside active video
  assert_req_active_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqOut |-> actIn);

  // R10: an empty rectangle never requests
  assert_empty_no_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((hSizeIn == '0) || (vSizeIn == '0)) |-> !reqOut);

  // R9: active flag delayed by two cycles
  assert_act_delay_R9: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (actOut == $past(actIn, 2)));

  // R5, R8: default floor holds until limits are reloaded
  assert_floor_default_R5: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !loadedSeen) |-> (dataOut >= LO_DEF));

  // R6, R4: default luma ceiling on odd samples
  assert_luma_ceiling_R6: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !loadedSeen && $past(xLsb, 2)) |-> (dataOut <= HIY_DEF));

  // R7, R4: default chroma ceiling on even samples
  assert_chroma_ceiling_R7: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !loadedSeen && !$past(xLsb, 2)) |-> (dataOut <= HIC_DEF));

endmodule

bind active_window_clip active_window_clip_chk #(.XW(XW), .YW(YW), .DW(DW)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .actIn  (actIn),
  .xLsb   (xIn[0]),
  .hSizeIn(hSizeIn),
  .vSizeIn(vSizeIn),
  .cfgLoad(cfgLoad),
  .reqOut (reqOut),
  .dataOut(dataOut),
  .actOut (actOut)
);

// File: tb/active_window_clip_tb_top.sv
module active_window_clip_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XW = 6;
  localparam int YW = 4;
  localparam int DW = 8;
  localparam int LINE_W = 16;
  localparam int LINES  = 6;
  localparam int GAP    = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          actIn;
  logic [XW-1:0] xIn;
  logic [YW-1:0] yIn;
  logic [XW-1:0] hOffIn;
  logic [XW-1:0] hSizeIn;
  logic [YW-1:0] vOffIn;
  logic [YW-1:0] vSizeIn;
  logic          cfgLoad;
  logic [DW-1:0] clipLoIn;
  logic [DW-1:0] clipHiLumaIn;
  logic [DW-1:0] clipHiChromaIn;
  logic          reqOut;
  logic [DW-1:0] srcData;
  logic [DW-1:0] dataOut;
  logic          actOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  active_window_clip #(.XW(XW), .YW(YW), .DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .actIn(actIn), .xIn(xIn), .yIn(yIn),
    .hOffIn(hOffIn), .hSizeIn(hSizeIn), .vOffIn(vOffIn), .vSizeIn(vSizeIn),
    .cfgLoad(cfgLoad), .clipLoIn(clipLoIn), .clipHiLumaIn(clipHiLumaIn),
    .clipHiChromaIn(clipHiChromaIn), .reqOut(reqOut), .srcData(srcData),
    .dataOut(dataOut), .actOut(actOut)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Bench model of the limits
  int mLo, mHiY, mHiC;
  int salt;
  string phase;

  // Two-deep expectation pipeline
  int    expData [4];
  bit    expAct  [4];
  string expTag  [4];
  int    cyc;
  int    skip;
  bit    prevReq;
  int    prevX, prevY;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int srcVal(input int x, input int y);
    return (x * 53 + y * 97 + salt) & 255;
  endfunction

  function automatic bit inRect(input int x, input int y);
    return (x >= int'(hOffIn)) && (x < int'(hOffIn) + int'(hSizeIn)) &&
           (y >= int'(vOffIn)) && (y < int'(vOffIn) + int'(vSizeIn));
  endfunction

  task automatic step(input bit act, input int x, input int y);
    bit    req;
    bit    luma;
    int    v, f, o;
    int    slot;
    string tag;
    @(posedge clk);
    #1;
    // R3: garbage on the source whenever nothing was requested
    srcData = prevReq ? DW'(srcVal(prevX, prevY)) : 8'hAA;
    actIn   = act;
    xIn     = XW'(x);
    yIn     = YW'(y);
    @(negedge clk);
    req = act && inRect(x, y);
    check((hSizeIn == 0 || vSizeIn == 0) ? "R10 request" : "R1 request",
          int'(reqOut), int'(req));
    // R4: odd index is luma
    luma = (x % 2) == 1;
    v = req ? srcVal(x, y) : (luma ? 16 : 128);
    f = (v < mLo) ? mLo : v;
    o = (f > (luma ? mHiY : mHiC)) ? (luma ? mHiY : mHiC) : f;
    tag = req ? "R2" : "R3";
    if (v < mLo) tag = {tag, " R5"};
    if (f > (luma ? mHiY : mHiC)) tag = {tag, luma ? " R6" : " R7"};
    tag = {phase, " ", tag, luma ? " R4 luma" : " R4 chroma"};
    slot = cyc % 4;
    expData[slot] = o;
    expAct[slot]  = act;
    expTag[slot]  = tag;
    if (cyc >= 2) begin
      slot = (cyc - 2) % 4;
      check("R9 actOut", int'(actOut), int'(expAct[slot]));
      if (skip > 0) skip--;
      else check(expTag[slot], int'(dataOut), expData[slot]);
    end
    prevReq = req;
    prevX = x;
    prevY = y;
    cyc++;
  endtask

  task automatic run_frame(input int s);
    salt = s;
    for (int y = 0; y < LINES; y++) begin
      for (int x = 0; x < LINE_W; x++) step(1'b1, x, y);
      for (int g = 0; g < GAP; g++) step(1'b0, 0, y);
    end
  endtask

  task automatic set_rect(input int ho, input int hs, input int vo, input int vs);
    hOffIn  = XW'(ho);
    hSizeIn = XW'(hs);
    vOffIn  = YW'(vo);
    vSizeIn = YW'(vs);
  endtask

  // R8: load new limits; in-flight samples with mixed limits are skipped
  task automatic load_limits(input int lo, input int hy, input int hc);
    clipLoIn = DW'(lo);
    clipHiLumaIn = DW'(hy);
    clipHiChromaIn = DW'(hc);
    @(posedge clk);
    #1;
    cfgLoad = 1'b1;
    @(posedge clk);
    #1;
    cfgLoad = 1'b0;
    mLo = lo;
    mHiY = hy;
    mHiC = hc;
    skip = 2;
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    actIn = 1'b0;
    cfgLoad = 1'b0;
    srcData = '0;
    xIn = '0;
    yIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset actOut", int'(actOut), 0);
    check("R9 reset dataOut", int'(dataOut), 0);
    check("R1 reset request", int'(reqOut), 0);
    mLo = 16;
    mHiY = 235;
    mHiC = 240;
    cyc = 0;
    skip = 0;
    prevReq = 1'b0;
    rstN = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    clipLoIn = 8'd0;
    clipHiLumaIn = 8'd255;
    clipHiChromaIn = 8'd255;
    set_rect(3, 8, 1, 3);
    do_reset();

    // R8 default limits, interior rectangle
    phase = "R8 default";
    run_frame(5);
    run_frame(131);

    // Loaded limits, rectangle flush to both line edges and the last line
    phase = "loaded";
    set_rect(0, LINE_W, 2, 4);
    load_limits(32, 200, 180);
    run_frame(17);
    run_frame(200);

    // R10: zero width, then zero height
    phase = "R10 empty";
    set_rect(4, 0, 0, LINES);
    run_frame(77);
    set_rect(5, 4, 2, 0);
    run_frame(91);

    // Conflicting limits: the ceiling wins
    phase = "R7 conflict";
    set_rect(6, 5, 0, 2);
    load_limits(150, 100, 120);
    run_frame(9);

    // R8: reset restores default limits
    set_rect(10, 6, 0, 1);
    do_reset();
    phase = "R8 after reset";
    run_frame(250);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule